// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a PHY management link. The host writes a 32-bit management frame into a data register. The block then sends that frame serially on MDIO, timed by a management clock MDC that it derives from the system clock. By default a run of 32 ones goes out ahead of the frame. A control bit can suppress this lead-in, which halves the transaction time. The frame goes out most significant bit first, and each new bit is launched when MDC falls.

When the frame's opcode is a read, the block stops driving the line from the turnaround bits onward. It samples the 16 bits that the PHY returns on the rising edges of MDC. When the last bit period ends, the data register holds those bits in its low half and a one-cycle completion pulse is raised.

MDC runs at the system clock divided by twice a programmable speed value. A zero speed keeps MDC stopped and holds a written frame pending. The frame and the speed can therefore be written in either order.

All host access is plain register writes. A transaction is a single fixed-length operation, not a stream, so there is no valid/ready handshake. Instead the host watches `busy` and `done`.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 while `busy` is low loads `wr_data` into the data register, which `rd_data` shows from the next cycle, and marks a frame pending. A data write while `busy` is high is ignored and has no effect on the running frame or its result.
- R2: A control write (`wr_sel`=1) sets the speed from `wr_data[SPEED_W-1:0]`. While the speed is zero, a pending frame does not start: `busy` and MDC stay low. A pending frame starts on the clock after a non-zero speed is present, or on the clock after a data write if the speed is already non-zero. `busy` is high from that clock until the frame ends.
- R3: While `busy` is high, each bit period lasts 2×speed system clocks. MDC is low for the first speed clocks of the period and high for the second speed clocks. MDC is low whenever `busy` is low.
- R4: When control bit `wr_data[8]` was 0 at the last control write, the first 32 bit periods drive MDIO to 1 with the output enabled. When that bit was 1, the frame starts at once.
- R5: The 32 frame bits go out in the order data-register bit 31 down to bit 0, one per bit period. The MDIO output changes during a transaction only at a falling edge of MDC.
- R6: When data-register bits [29:28] are 2'b10 at start (read), `mdio_oe` is low from frame bit 14 (turnaround) to the end. `mdio_i` is sampled at each MDC rising edge of frame bits 16..31, first sample as the most significant bit.
- R7: One system clock after the last bit period ends, `done` is high for exactly one cycle and `busy` is low. The data register then holds 0 in bits [31:16], and in bits [15:0] the sampled bits for a read, or 0 otherwise.
- R8: A control write while `busy` is high does not change the timing or preamble choice of the running frame. It applies to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the data register, 1 the control word |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Data register contents |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest condition to reach is a frame that is pending but cannot start because the speed is zero. It must leave MDC flat for as long as it waits, and then launch on the exact clock after the speed write. The bench writes the frame first, idles for many cycles with a zero speed, and then supplies the speed. Writes that land mid-frame are also hard to reach from the ports: both a data write and a speed change arrive while a slow frame is running, and the bench checks that neither disturbs that frame or its result. A behavioural model predicts MDC, the MDIO pins, `busy`, `done` and the data register on every clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_W       = 32;
  localparam int PRE_W         = 32;
  localparam int TOTAL_W       = FRAME_W + PRE_W;
  localparam int BIT_W         = $clog2(TOTAL_W);
  localparam int F_TURN        = 14;
  localparam int F_DATA        = 16;
  localparam int CTL_NOPRE_BIT = 8;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
  parameter int SPEED_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               run,
  input  logic [SPEED_W-1:0] div,
  output logic               mdc,
  output logic               rise_tick,
  output logic               fall_tick
);
  localparam logic [SPEED_W-1:0] ONE = SPEED_W'(1);

  logic [SPEED_W-1:0] div_q;
  logic [SPEED_W-1:0] cnt_q;
  logic               phase_q;
  logic               wrap;

  assign wrap = (cnt_q == (div_q - ONE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (start) begin
      div_q   <= div;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign mdc       = run & phase_q;
  assign rise_tick = run & ~phase_q & wrap;
  assign fall_tick = run &  phase_q & wrap;
endmodule

// File: rtl/mdio_mgmt_shifter.sv
module mdio_mgmt_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               start,
  input  logic               skip_pre,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               active,
  input  logic               mdio_i,
  output logic [FRAME_W-1:0] word,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               last
);
  localparam logic [BIT_W-1:0] PRE_L  = BIT_W'(PRE_W);
  localparam logic [BIT_W-1:0] LAST_L = BIT_W'(TOTAL_W - 1);
  localparam logic [BIT_W-1:0] TURN_L = BIT_W'(PRE_W + F_TURN);
  localparam logic [BIT_W-1:0] DATA_L = BIT_W'(PRE_W + F_DATA);
  localparam logic [BIT_W-1:0] STEP   = BIT_W'(1);

  logic [FRAME_W-1:0] word_q;
  logic [BIT_W-1:0]   bit_q;
  logic               rd_q;
  logic               smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      if (load) word_q <= load_val;
      if (start) begin
        bit_q <= skip_pre ? PRE_L : '0;
        rd_q  <= (word_q[FRAME_W-3:FRAME_W-4] == OP_READ);
        smp_q <= 1'b0;
      end
      if (rise_tick) smp_q <= (rd_q && (bit_q >= DATA_L)) ? mdio_i : 1'b0;
      if (fall_tick) begin
        bit_q <= bit_q + STEP;
        if (bit_q >= PRE_L) word_q <= {word_q[FRAME_W-2:0], smp_q};
      end
    end
  end

  assign word    = word_q;
  assign mdio_o  = active & ((bit_q < PRE_L) | word_q[FRAME_W-1]);
  assign mdio_oe = active & ~(rd_q & (bit_q >= TURN_L));
  assign last    = fall_tick & (bit_q == LAST_L);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int SPEED_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [SPEED_W-1:0] speed_q;
  logic               nopre_q;
  logic               pending_q;
  logic               active_q;
  logic               done_q;
  logic               data_wr;
  logic               ctl_wr;
  logic               start;
  logic               rise_tick;
  logic               fall_tick;
  logic               last;

  assign data_wr = wr_en & (wr_sel == SEL_DATA) & ~active_q;
  assign ctl_wr  = wr_en & (wr_sel == SEL_CTL);
  assign start   = pending_q & ~active_q & (speed_q != '0) & ~data_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed_q   <= '0;
      nopre_q   <= 1'b0;
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        speed_q <= wr_data[SPEED_W-1:0];
        nopre_q <= wr_data[CTL_NOPRE_BIT];
      end
      if (data_wr)    pending_q <= 1'b1;
      else if (start) pending_q <= 1'b0;
      if (start)      active_q <= 1'b1;
      else if (last)  active_q <= 1'b0;
      done_q <= last;
    end
  end

  mdio_mgmt_clkdiv #(.SPEED_W(SPEED_W)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (active_q),
    .div       (speed_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_mgmt_shifter shf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_wr),
    .load_val  (wr_data),
    .start     (start),
    .skip_pre  (nopre_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .active    (active_q),
    .mdio_i    (mdio_i),
    .word      (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .last      (last)
  );

  assign busy = active_q;
  assign done = done_q;
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int SPEED_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [31:0]        wr_data,
  input logic [31:0]        rd_data,
  input logic               busy,
  input logic               done,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic [SPEED_W-1:0] speed_q
);
  assert_data_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !busy) |=> (rd_data == $past(wr_data)));

  assert_start_needs_speed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(speed_q) != '0));

  assert_mdc_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_launch_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  assert_release_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(mdio_oe)) |-> $fell(mdc));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.SPEED_W(SPEED_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .busy    (busy),
  .done    (done),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .speed_q (speed_q)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int done_seen = 0;
  int done_exp = 0;
  bit model_on = 0;

  // behavioural reference state
  bit          m_active, m_pending, m_done, m_read, m_nopre;
  int          m_speed, m_d, m_n, m_t;
  logic [31:0] m_word, m_frame;
  logic [15:0] m_resp;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] dat);
    return {2'b01, op, phy, rg, 2'b10, dat};
  endfunction

  // model update at the active edge, using pre-edge values
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_active = 0; m_pending = 0; m_done = 0; m_read = 0; m_nopre = 0;
      m_speed = 0; m_d = 1; m_n = 64; m_t = 0; m_word = '0; m_frame = '0;
    end else begin
      bit o_act, o_pend, o_nopre, dwr, strt;
      int o_spd;
      o_act = m_active; o_pend = m_pending; o_spd = m_speed; o_nopre = m_nopre;
      dwr  = wr_en && !wr_sel && !o_act;
      strt = o_pend && !o_act && (o_spd != 0) && !dwr;
      m_done = 0;
      if (o_act) begin
        if (m_t == m_n * 2 * m_d - 1) begin
          m_active = 0; m_done = 1;
          m_word = m_read ? {16'h0000, m_resp} : 32'h0;
        end else m_t++;
      end
      if (strt) begin
        m_active = 1; m_t = 0; m_d = o_spd; m_n = o_nopre ? 32 : 64;
        m_read = (m_word[29:28] == 2'b10); m_frame = m_word; m_pending = 0;
      end
      if (dwr) begin m_word = wr_data; m_pending = 1; end
      if (wr_en && wr_sel) begin m_speed = int'(wr_data[5:0]); m_nopre = wr_data[8]; end
    end
  end

  // comparison and PHY response, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      int b, f;
      bit e_mdc, e_oe, e_o;
      b = m_t / (2 * m_d) + (64 - m_n);
      f = b - 32;
      e_mdc = m_active && ((m_t % (2 * m_d)) >= m_d);
      e_oe  = m_active && !(m_read && f >= 14);
      e_o   = (b < 32) ? 1'b1 : m_frame[31 - f];
      check(mdc == e_mdc, "R3 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      check(busy == m_active, "R2 busy", {31'b0, busy}, {31'b0, m_active});
      check(done == m_done, "R7 done", {31'b0, done}, {31'b0, m_done});
      check(mdio_oe == e_oe, "R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe && mdio_oe)
        check(mdio_o == e_o, (b < 32) ? "R4 preamble" : "R5 frame bit",
              {31'b0, mdio_o}, {31'b0, e_o});
      if (!m_active) check(rd_data == m_word, "R1 data register", rd_data, m_word);
      if (done) done_seen++;
      if (m_active && m_read && f >= 16) mdio_i = m_resp[31 - f];
      else mdio_i = 1'b1;
    end
  end

  task automatic wr(input logic sel, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_active || m_pending) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mdc == 1'b0 && busy == 1'b0 && done == 1'b0, "R3 reset idle",
          {29'b0, mdc, busy, done}, 32'h0);
    check(rd_data == 32'h0, "R1 reset data", rd_data, 32'h0);
    model_on = 1;

    // R4 R5: write opcode, speed 2, preamble on
    m_resp = 16'h0;
    wr(1'b1, 32'h0000_0002);
    wr(1'b0, mk(2'b01, 5'h11, 5'h0A, 16'hBEEF));
    done_exp++;
    wait_idle();
    check(rd_data == 32'h0, "R7 write result", rd_data, 32'h0);

    // R6: read, speed 3, preamble suppressed
    m_resp = 16'hA5C3;
    wr(1'b1, 32'h0000_0103);
    wr(1'b0, mk(2'b10, 5'h03, 5'h1F, 16'h0000));
    done_exp++;
    wait_idle();
    check(rd_data == 32'h0000_A5C3, "R6 read capture", rd_data, 32'h0000_A5C3);

    // R2: data first, speed zero holds the frame off
    m_resp = 16'h3C5A;
    wr(1'b1, 32'h0000_0000);
    wr(1'b0, mk(2'b10, 5'h1E, 5'h01, 16'h0000));
    repeat (40) @(negedge clk);
    check(busy == 1'b0 && mdc == 1'b0, "R2 held off", {30'b0, busy, mdc}, 32'h0);
    wr(1'b1, 32'h0000_0001);
    done_exp++;
    wait_idle();
    check(rd_data == 32'h0000_3C5A, "R2 late start read", rd_data, 32'h0000_3C5A);

    // R8 R1: slow write frame disturbed by mid-frame writes
    m_resp = 16'h0;
    wr(1'b1, 32'h0000_0004);
    wr(1'b0, mk(2'b01, 5'h05, 5'h15, 16'h1357));
    done_exp++;
    repeat (30) @(negedge clk);
    wr(1'b0, mk(2'b10, 5'h00, 5'h00, 16'hFFFF));
    wr(1'b1, 32'h0000_0101);
    wait_idle();
    check(rd_data == 32'h0, "R8 unchanged result", rd_data, 32'h0);
    check(busy == 1'b0, "R1 ignored write left nothing pending", {31'b0, busy}, 32'h0);

    // back to back at the minimum divisor, no preamble
    m_resp = 16'h8001;
    wr(1'b0, mk(2'b01, 5'h1F, 5'h1F, 16'h0F0F));
    done_exp++;
    wait_idle();
    wr(1'b0, mk(2'b10, 5'h0C, 5'h03, 16'h0000));
    done_exp++;
    wait_idle();
    check(rd_data == 32'h0000_8001, "R6 min divisor read", rd_data, 32'h0000_8001);
    check(done_seen == done_exp, "R7 completion count", done_seen, done_exp);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule